// File: doc/BRIEF.md
# Parallel-Port Sample Readout Interface

This block sits on the device side of a plain parallel port. It lets a host read two channels of captured samples, exchange command bytes through a one-byte mailbox, and identify the device. No handshake picks the byte on the data bus. The host chooses it with two of its control lines (auto-feed and select-in). One combination gives a fixed identification byte, so the host can detect the device by reading the bus.

Sample readout runs from an auto-incrementing pointer into the readout window of the sample SRAMs. The window runs from 0x4000 to 0x7FFF. Each completed strobe pulse on a channel selection advances the pointer. Past the top of the window the pointer wraps back to its base. In scroll mode the channel selections return the live ADC bytes instead of stored samples.

The mailbox is half duplex and is shared between the host and the on-board controller. Whichever side wrote last reads zero, and the other side reads the byte. A strobe pulse classifier decides what each strobe means. It has four states:
- `ST_IDLE`: no pulse.
- `ST_PULSE_RD`: a sample-read pulse. Its release, the transition `ST_PULSE_RD -> ST_IDLE`, advances the pointer.
- `ST_PULSE_MB`: a mailbox write. Entering it from `ST_IDLE` latches the host byte.
- `ST_PULSE_OTHER`: any other pulse, which has no effect.

Every pulse state returns to `ST_IDLE` when strobe is released.

Top module: `pp_readout_if`

## Requirements
- R1: In reset, the pointer (`mem_addr`) is 0x4000, `pp_data_oe` is 0, `pp_data_o` is 0, both mailbox views read 0, and the classifier is in `ST_IDLE`.
- R2: The output byte is registered and appears one cycle after the select lines are sampled. The source is chosen by {select-in, auto-feed}: 00 gives channel A (`mem_a_rdata` at the pointer), 01 gives channel B (`mem_b_rdata`), 10 gives the host view of the mailbox, and 11 gives the constant 0x55.
- R3: `pp_data_oe` follows `host_dir_in` one cycle later. While `pp_data_oe` is 0, `pp_data_o` is 0.
- R4: A strobe pulse that begins with select-in negated advances the pointer by one. The advance takes effect on the clock edge that sees strobe released. A pulse that begins with select-in asserted never moves the pointer.
- R5: Advancing from 0x7FFF returns the pointer to 0x4000.
- R6: `ptr_rewind` sets the pointer to 0x4000 on the next edge, and it takes priority over a simultaneous advance.
- R7: The host writes the mailbox only on the edge where strobe is first seen asserted while select-in and init are asserted and `host_dir_in` is 0. The byte written is `pp_data_i`. A pulse with init negated writes nothing.
- R8: After a host write, `dev_mb_rdata` shows the byte and the host view reads 0. After a device write (`dev_mb_wr`), `dev_mb_rdata` reads 0 and the host view shows the byte.
- R9: When a host write and a device write fall on the same edge, the host byte is kept and the device reads it.
- R10: While `scroll_en` is 1, selections 00 and 01 return `adc_a` and `adc_b` in place of the SRAM bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hs_strobe | input | 1 | Host strobe asserted |
| hs_feed | input | 1 | Host auto-feed asserted (source select, low bit) |
| hs_select | input | 1 | Host select-in asserted (source select, high bit) |
| hs_init | input | 1 | Host init asserted (mailbox write qualifier) |
| host_dir_in | input | 1 | Host port set to input; the device may drive the bus |
| pp_data_i | input | 8 | Bus byte driven by the host |
| pp_data_o | output | 8 | Bus byte driven by the device |
| pp_data_oe | output | 1 | Device bus drive enable |
| mem_addr | output | 15 | Readout pointer into both sample SRAMs |
| mem_a_rdata | input | 8 | Channel A SRAM byte at `mem_addr` |
| mem_b_rdata | input | 8 | Channel B SRAM byte at `mem_addr` |
| scroll_en | input | 1 | Live ADC mode |
| adc_a | input | 8 | Live channel A ADC byte |
| adc_b | input | 8 | Live channel B ADC byte |
| ptr_rewind | input | 1 | Return the pointer to the window base |
| dev_mb_wr | input | 1 | Controller writes the mailbox |
| dev_mb_wdata | input | 8 | Controller mailbox byte |
| dev_mb_rdata | output | 8 | Controller view of the mailbox |

## Verification
Each result has a fixed latency:
- The bus byte and its enable appear one cycle after the control and direction lines are sampled.
- The pointer moves on the edge that sees strobe released. The byte read at the new address follows one cycle after that.
- The controller's mailbox view changes on the edge of the write.
- The host's mailbox view reaches the bus one cycle after that edge.

A behavioural reference model in the bench advances its own pointer, mailbox and pulse state on every rising edge. All device outputs are compared against it on every falling edge, so each comparison falls after all of the registers involved have updated. The directed checks for each requirement wait the stated number of edges before sampling.

// File: rtl/pp_rd_pkg.sv
package pp_rd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE        = 2'd0,
        ST_PULSE_RD    = 2'd1,
        ST_PULSE_MB    = 2'd2,
        ST_PULSE_OTHER = 2'd3
    } strobe_st_t;

    // encoded as {select-in, auto-feed}
    typedef enum logic [1:0] {
        SRC_CHAN_A = 2'b00,
        SRC_CHAN_B = 2'b01,
        SRC_MBOX   = 2'b10,
        SRC_ID     = 2'b11
    } bus_src_t;
endpackage

// File: rtl/pp_strobe_fsm.sv
module pp_strobe_fsm
    import pp_rd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic select,
    input  logic init,
    input  logic host_dir_in,
    output logic adv,
    output logic mb_wr
);
    strobe_st_t state, state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (strobe) begin
                    if (select && init && !host_dir_in) state_nxt = ST_PULSE_MB;
                    else if (!select)                   state_nxt = ST_PULSE_RD;
                    else                                state_nxt = ST_PULSE_OTHER;
                end
            end
            ST_PULSE_RD, ST_PULSE_MB, ST_PULSE_OTHER: begin
                if (!strobe) state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        adv   = 1'b0;
        mb_wr = 1'b0;
        unique case (state)
            ST_IDLE:        mb_wr = (state_nxt == ST_PULSE_MB);
            ST_PULSE_RD:    adv   = (state_nxt == ST_IDLE);
            ST_PULSE_MB:    ;
            ST_PULSE_OTHER: ;
            default:        ;
        endcase
    end
endmodule

// File: rtl/pp_sample_ptr.sv
module pp_sample_ptr #(
    parameter int                ADDR_W = 15,
    parameter logic [ADDR_W-1:0] BASE   = 15'h4000,
    parameter logic [ADDR_W-1:0] LAST   = 15'h7FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rewind,
    input  logic              adv,
    output logic [ADDR_W-1:0] ptr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ptr <= BASE;
        else if (rewind) ptr <= BASE;
        else if (adv)    ptr <= (ptr == LAST) ? BASE : ptr + 1'b1;
    end
endmodule

// File: rtl/pp_mailbox.sv
module pp_mailbox #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              dev_wr,
    input  logic [DATA_W-1:0] dev_wdata,
    output logic [DATA_W-1:0] host_view,
    output logic [DATA_W-1:0] dev_view
);
    logic [DATA_W-1:0] slot;
    logic              host_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot      <= '0;
            host_last <= 1'b0;
        end else if (host_wr) begin
            slot      <= host_wdata;
            host_last <= 1'b1;
        end else if (dev_wr) begin
            slot      <= dev_wdata;
            host_last <= 1'b0;
        end
    end

    assign host_view = host_last ? '0 : slot;
    assign dev_view  = host_last ? slot : '0;
endmodule

// File: rtl/pp_readout_if.sv
module pp_readout_if
    import pp_rd_pkg::*;
#(
    parameter int                DATA_W  = 8,
    parameter int                ADDR_W  = 15,
    parameter logic [ADDR_W-1:0] RD_BASE = 15'h4000,
    parameter logic [ADDR_W-1:0] RD_LAST = 15'h7FFF,
    parameter logic [DATA_W-1:0] ID_BYTE = 8'h55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hs_strobe,
    input  logic              hs_feed,
    input  logic              hs_select,
    input  logic              hs_init,
    input  logic              host_dir_in,
    input  logic [DATA_W-1:0] pp_data_i,
    output logic [DATA_W-1:0] pp_data_o,
    output logic              pp_data_oe,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_a_rdata,
    input  logic [DATA_W-1:0] mem_b_rdata,
    input  logic              scroll_en,
    input  logic [DATA_W-1:0] adc_a,
    input  logic [DATA_W-1:0] adc_b,
    input  logic              ptr_rewind,
    input  logic              dev_mb_wr,
    input  logic [DATA_W-1:0] dev_mb_wdata,
    output logic [DATA_W-1:0] dev_mb_rdata
);
    logic              ptr_adv;
    logic              mb_host_wr;
    logic [DATA_W-1:0] mb_host_view;
    logic [DATA_W-1:0] bus_nxt;
    bus_src_t          src;

    pp_strobe_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe      (hs_strobe),
        .select      (hs_select),
        .init        (hs_init),
        .host_dir_in (host_dir_in),
        .adv         (ptr_adv),
        .mb_wr       (mb_host_wr)
    );

    pp_sample_ptr #(.ADDR_W(ADDR_W), .BASE(RD_BASE), .LAST(RD_LAST)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .rewind (ptr_rewind),
        .adv    (ptr_adv),
        .ptr    (mem_addr)
    );

    pp_mailbox #(.DATA_W(DATA_W)) u_mbox (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (mb_host_wr),
        .host_wdata (pp_data_i),
        .dev_wr     (dev_mb_wr),
        .dev_wdata  (dev_mb_wdata),
        .host_view  (mb_host_view),
        .dev_view   (dev_mb_rdata)
    );

    assign src = bus_src_t'({hs_select, hs_feed});

    always_comb begin
        unique case (src)
            SRC_CHAN_A: bus_nxt = scroll_en ? adc_a : mem_a_rdata;
            SRC_CHAN_B: bus_nxt = scroll_en ? adc_b : mem_b_rdata;
            SRC_MBOX:   bus_nxt = mb_host_view;
            SRC_ID:     bus_nxt = ID_BYTE;
            default:    bus_nxt = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pp_data_o  <= '0;
            pp_data_oe <= 1'b0;
        end else begin
            pp_data_o  <= host_dir_in ? bus_nxt : '0;
            pp_data_oe <= host_dir_in;
        end
    end
endmodule

// File: rtl/pp_readout_chk.sv
module pp_readout_chk #(
    parameter int                ADDR_W  = 15,
    parameter logic [ADDR_W-1:0] RD_BASE = 15'h4000,
    parameter logic [ADDR_W-1:0] RD_LAST = 15'h7FFF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_dir_in,
    input logic              hs_strobe,
    input logic              hs_select,
    input logic              hs_feed,
    input logic [7:0]        pp_data_i,
    input logic [7:0]        pp_data_o,
    input logic              pp_data_oe,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              ptr_adv,
    input logic              ptr_rewind,
    input logic              mb_host_wr,
    input logic [7:0]        dev_mb_rdata
);
    assert_id_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_dir_in && hs_select && hs_feed) |=> (pp_data_o == 8'h55));

    assert_oe_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
        host_dir_in |=> pp_data_oe);

    assert_oe_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !host_dir_in |=> (!pp_data_oe && pp_data_o == 8'h00));

    assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_adv && !ptr_rewind && mem_addr != RD_LAST) |=> (mem_addr == $past(mem_addr) + 1'b1));

    assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_adv && !ptr_rewind && mem_addr == RD_LAST) |=> (mem_addr == RD_BASE));

    assert_rewind_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_rewind |=> (mem_addr == RD_BASE));

    assert_no_write_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hs_strobe) && !hs_select) |-> !mb_host_wr);

    assert_dev_view_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mb_host_wr |=> (dev_mb_rdata == $past(pp_data_i)));
endmodule

bind pp_readout_if pp_readout_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_dir_in  (host_dir_in),
    .hs_strobe    (hs_strobe),
    .hs_select    (hs_select),
    .hs_feed      (hs_feed),
    .pp_data_i    (pp_data_i),
    .pp_data_o    (pp_data_o),
    .pp_data_oe   (pp_data_oe),
    .mem_addr     (mem_addr),
    .ptr_adv      (ptr_adv),
    .ptr_rewind   (ptr_rewind),
    .mb_host_wr   (mb_host_wr),
    .dev_mb_rdata (dev_mb_rdata)
);

// File: tb/test_pp_readout_if.sv
module test_pp_readout_if;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hs_strobe = 0, hs_feed = 0, hs_select = 0, hs_init = 0;
    logic        host_dir_in = 0;
    logic [7:0]  pp_data_i = 0;
    logic [7:0]  pp_data_o;
    logic        pp_data_oe;
    logic [14:0] mem_addr;
    logic [7:0]  mem_a_rdata, mem_b_rdata;
    logic        scroll_en = 0;
    logic [7:0]  adc_a = 0, adc_b = 0;
    logic        ptr_rewind = 0;
    logic        dev_mb_wr = 0;
    logic [7:0]  dev_mb_wdata = 0;
    logic [7:0]  dev_mb_rdata;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    // SRAM stand-ins: content derived from the address
    function automatic logic [7:0] fa(input logic [14:0] a); return a[7:0] ^ 8'h3C; endfunction
    function automatic logic [7:0] fb(input logic [14:0] a); return a[7:0] + 8'h11; endfunction
    assign mem_a_rdata = fa(mem_addr);
    assign mem_b_rdata = fb(mem_addr);

    pp_readout_if i_pp_readout_if (
        .clk(clk), .rst_n(rst_n), .hs_strobe(hs_strobe), .hs_feed(hs_feed),
        .hs_select(hs_select), .hs_init(hs_init), .host_dir_in(host_dir_in),
        .pp_data_i(pp_data_i), .pp_data_o(pp_data_o), .pp_data_oe(pp_data_oe),
        .mem_addr(mem_addr), .mem_a_rdata(mem_a_rdata), .mem_b_rdata(mem_b_rdata),
        .scroll_en(scroll_en), .adc_a(adc_a), .adc_b(adc_b), .ptr_rewind(ptr_rewind),
        .dev_mb_wr(dev_mb_wr), .dev_mb_wdata(dev_mb_wdata), .dev_mb_rdata(dev_mb_rdata)
    );

    // behavioural reference model
    int          m_phase = 0;   // 0 none, 1 read pulse, 2 mailbox pulse, 3 other
    int          m_ptr   = 'h4000;
    logic [7:0]  m_mbv   = 0;
    bit          m_hostlast = 0;
    logic [7:0]  e_data  = 0;
    bit          e_oe    = 0;

    always @(posedge clk) begin
        logic [7:0] v;
        bit hw, adv;
        if (!rst_n) begin
            m_phase = 0; m_ptr = 'h4000; m_mbv = 0; m_hostlast = 0; e_data = 0; e_oe = 0;
        end else begin
            case ({hs_select, hs_feed})
                2'b00:   v = scroll_en ? adc_a : fa(15'(m_ptr));
                2'b01:   v = scroll_en ? adc_b : fb(15'(m_ptr));
                2'b10:   v = m_hostlast ? 8'h00 : m_mbv;
                default: v = 8'h55;
            endcase
            e_data = host_dir_in ? v : 8'h00;
            e_oe   = host_dir_in;
            hw = 0; adv = 0;
            if (m_phase == 0 && hs_strobe) begin
                if (hs_select && hs_init && !host_dir_in) begin hw = 1; m_phase = 2; end
                else if (!hs_select) m_phase = 1;
                else m_phase = 3;
            end else if (m_phase != 0 && !hs_strobe) begin
                adv = (m_phase == 1);
                m_phase = 0;
            end
            if (ptr_rewind) m_ptr = 'h4000;
            else if (adv)   m_ptr = (m_ptr == 'h7FFF) ? 'h4000 : m_ptr + 1;
            if (hw) begin m_mbv = pp_data_i; m_hostlast = 1; end
            else if (dev_mb_wr) begin m_mbv = dev_mb_wdata; m_hostlast = 0; end
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (!done) begin
            vectors++;
            if (pp_data_o !== e_data) begin
                errors++; $display("FAIL model R2 pp_data_o act=%h exp=%h", pp_data_o, e_data);
            end
            if (pp_data_oe !== e_oe) begin
                errors++; $display("FAIL model R3 pp_data_oe act=%b exp=%b", pp_data_oe, e_oe);
            end
            if (mem_addr !== 15'(m_ptr)) begin
                errors++; $display("FAIL model R4 mem_addr act=%h exp=%h", mem_addr, m_ptr);
            end
            if (dev_mb_rdata !== (m_hostlast ? m_mbv : 8'h00)) begin
                errors++; $display("FAIL model R8 dev_mb_rdata act=%h exp=%h", dev_mb_rdata,
                                   m_hostlast ? m_mbv : 8'h00);
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // returns at the negedge where strobe is released
    task automatic pulse();
        @(negedge clk) hs_strobe = 1;
        @(negedge clk) hs_strobe = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog expired act=running exp=finished");
        finish_run();
    end

    initial begin
        wait_neg(4);
        chk("R1 reset pointer", mem_addr, 'h4000);
        chk("R1 reset oe", pp_data_oe, 0);
        chk("R1 reset dev view", dev_mb_rdata, 0);
        rst_n = 1;

        // R2 source selection
        @(negedge clk) begin host_dir_in = 1; hs_select = 0; hs_feed = 0; end
        @(negedge clk) chk("R2 chan A", pp_data_o, 8'h3C);
        hs_feed = 1;
        @(negedge clk) chk("R2 chan B", pp_data_o, 8'h11);
        hs_select = 1;
        @(negedge clk) chk("R2 id byte", pp_data_o, 8'h55);
        hs_feed = 0;
        @(negedge clk) chk("R8 empty mailbox host view", pp_data_o, 8'h00);

        // R3 direction
        host_dir_in = 0; hs_select = 1; hs_feed = 1;
        @(negedge clk) begin
            chk("R3 oe off", pp_data_oe, 0);
            chk("R3 data zero", pp_data_o, 0);
        end

        // R4 pointer advance
        host_dir_in = 1; hs_select = 0; hs_feed = 0;
        for (int i = 0; i < 5; i++) pulse();
        @(negedge clk) chk("R4 five pulses", mem_addr, 'h4005);
        @(negedge clk) chk("R4 byte at new address", pp_data_o, 8'h39);

        // R7 / R8 host mailbox write
        host_dir_in = 0; hs_select = 1; hs_init = 1; pp_data_i = 8'hA7;
        pulse();
        chk("R7 host write lands", dev_mb_rdata, 8'hA7);
        hs_init = 0; pp_data_i = 8'h5A;
        pulse();
        @(negedge clk) chk("R7 init negated no write", dev_mb_rdata, 8'hA7);
        chk("R4 select pulses hold pointer", mem_addr, 'h4005);
        host_dir_in = 1; hs_feed = 0;
        @(negedge clk) chk("R8 writer host reads zero", pp_data_o, 8'h00);
        host_dir_in = 0; hs_select = 0; hs_init = 1;
        pulse();
        @(negedge clk) begin
            chk("R7 read pulse no write", dev_mb_rdata, 8'hA7);
            chk("R4 pulse advances", mem_addr, 'h4006);
        end

        // R8 device write
        dev_mb_wr = 1; dev_mb_wdata = 8'h3E;
        @(negedge clk) begin dev_mb_wr = 0; chk("R8 writer device reads zero", dev_mb_rdata, 0); end
        host_dir_in = 1; hs_select = 1; hs_feed = 0;
        @(negedge clk) chk("R8 host sees device byte", pp_data_o, 8'h3E);

        // R9 collision
        host_dir_in = 0; hs_init = 1; hs_strobe = 1; pp_data_i = 8'h81;
        dev_mb_wr = 1; dev_mb_wdata = 8'h42;
        @(negedge clk) begin hs_strobe = 0; dev_mb_wr = 0; end
        chk("R9 host wins", dev_mb_rdata, 8'h81);
        wait_neg(1);

        // R10 scroll mode
        scroll_en = 1; adc_a = 8'hC3; adc_b = 8'h9D;
        host_dir_in = 1; hs_select = 0; hs_feed = 0;
        @(negedge clk) chk("R10 live A", pp_data_o, 8'hC3);
        hs_feed = 1;
        @(negedge clk) chk("R10 live B", pp_data_o, 8'h9D);
        scroll_en = 0; hs_feed = 0;

        // R6 rewind
        ptr_rewind = 1;
        @(negedge clk) begin ptr_rewind = 0; chk("R6 rewind", mem_addr, 'h4000); end
        pulse();
        @(negedge clk) chk("R4 advance before rewind test", mem_addr, 'h4001);
        hs_strobe = 1;
        @(negedge clk) begin hs_strobe = 0; ptr_rewind = 1; end
        @(negedge clk) begin ptr_rewind = 0; chk("R6 rewind beats advance", mem_addr, 'h4000); end

        // R5 wrap
        for (int i = 0; i < 16383; i++) pulse();
        @(negedge clk) chk("R5 top of window", mem_addr, 'h7FFF);
        pulse();
        @(negedge clk) chk("R5 wrap to base", mem_addr, 'h4000);

        wait_neg(2);
        finish_run();
    end
endmodule